// File: doc/BRIEF.md
# ACPI Embedded Controller Host Mailbox

This block is the mailbox between a host and an embedded controller, shaped after the ACPI embedded controller model. The host sees two byte-wide addresses. The data port carries bytes in both directions. The command/status port takes command bytes on write and returns the status byte on read. The controller sees a small register window: four host-to-controller byte slots, four controller-to-host byte slots, a status register and a control register. It also has two interrupt outputs, one for "input buffer filled" and one for "output buffer drained".

Host-written and controller-written bytes live in separate banks. Each side can therefore post a transfer while the other side still has one pending. Hardware keeps the input-full (IBF), output-full (OBF) and command (CMD) flags. The controller tells a command byte from a data byte by reading CMD, because both kinds of byte land in the same controller-side slot 0. After reset the mailbox moves one byte per transfer. A control bit switches it to four-byte transfers.

Each direction has a lane sequencer with two states. SEQ_HOME points at byte 0. SEQ_FILL means a four-byte transfer is part-way done, and a counter names the current byte. There are four transitions:
- SEQ_HOME to SEQ_FILL on a data access in four-byte mode.
- SEQ_FILL to SEQ_FILL on each middle byte.
- SEQ_FILL to SEQ_HOME on the access to byte 3.
- Any state to SEQ_HOME on a restart. A restart is a command write (write direction), a controller write of output slot 0 (read direction), or any write of the control register (both directions).

Top module: `ecmb_mailbox`

## Requirements
- R1: After reset, IBF, OBF, CMD, every control bit and every byte slot are 0, legacy (single-byte) mode is active, and both interrupt outputs are low.
- R2: In legacy mode, a host write with host_sel=0 stores the byte in controller slot 0 (ctl_addr 0), sets IBF and clears CMD.
- R3: A host write with host_sel=1 stores the byte in controller slot 0, sets CMD and IBF, and returns the write sequencer to byte 0.
- R4: A controller read strobe at ctl_addr 0 clears IBF. If a host write sets IBF in the same cycle, IBF stays 1.
- R5: A controller write at ctl_addr 4 stores output byte 0, sets OBF and returns the read sequencer to byte 0. A host read with host_sel=0 returns the output byte at the read position. In legacy mode that read clears OBF. If OBF is set and cleared in the same cycle, setting wins.
- R6: irq_ibf is high for exactly the one cycle after IBF goes from 0 to 1. irq_obf is high for exactly the one cycle after OBF goes from 1 to 0. Neither output pulses on any other change.
- R7: The status byte is {0, SMI_EVT, SCI_EVT, BURST, CMD, 0, IBF, OBF} (bit 7 down to bit 0). It is returned on host_rdata when host_sel=1 and on ctl_rdata at ctl_addr 8. Host status reads have no side effect.
- R8: The control register at ctl_addr 9 holds bit0 four-byte mode, bit1 BURST, bit5 SCI_EVT and bit6 SMI_EVT. Other bits read 0. SCI_EVT and SMI_EVT only appear in status and drive no output.
- R9: In four-byte mode, successive host data writes fill controller slots 0, 1, 2, 3 in that order. Only the write to byte 3 sets IBF. Each data write clears CMD.
- R10: In four-byte mode, successive host data reads return output slots 0, 1, 2, 3 (controller offsets 4 to 7). Only the read of byte 3 clears OBF.
- R11: Host accesses never change the output slots, and controller writes never change the input slots. Output slots 1 to 3 change only the slots themselves, not the flags. Controller writes to offsets 0 to 3 are ignored.
- R12: Any write of the control register returns both sequencers to byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 1 | Host port select: 0 data, 1 command/status |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (status or output byte) |
| ctl_addr | input | 4 | Controller register offset |
| ctl_wr | input | 1 | Controller write strobe |
| ctl_rd | input | 1 | Controller read strobe |
| ctl_wdata | input | 8 | Controller write byte |
| ctl_rdata | output | 8 | Controller read byte |
| irq_ibf | output | 1 | Input-full interrupt pulse |
| irq_obf | output | 1 | Output-drained interrupt pulse |

## Verification
Two pairs of events can fall in the same cycle: a host write that sets IBF while the controller's read strobe on slot 0 clears it, and a controller write of output slot 0 that sets OBF while a host data read clears it. Directed steps place each pair on the same clock edge. The bench then judges by the flag in the status byte on the next cycle and by whether an interrupt pulse appeared. A long pseudo-random run mixes both sides' strobes freely, and the behavioural model is compared against every output on every clock, so more of these collisions occur there.

// File: rtl/ecmb_pkg.sv
package ecmb_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        SEQ_HOME,
        SEQ_FILL
    } seq_state_e;

    // status byte positions
    localparam int ST_OBF   = 0;
    localparam int ST_IBF   = 1;
    localparam int ST_CMD   = 3;
    localparam int ST_BURST = 4;
    localparam int ST_SCI   = 5;
    localparam int ST_SMI   = 6;

    // control byte positions
    localparam int CT_WIDE  = 0;
    localparam int CT_BURST = 1;
    localparam int CT_SCI   = 5;
    localparam int CT_SMI   = 6;

    function automatic logic [BYTE_W-1:0] pack_status(
        input logic obf, input logic ibf, input logic cmd,
        input logic burst, input logic sci, input logic smi);
        logic [BYTE_W-1:0] s;
        s = '0;
        s[ST_OBF]   = obf;
        s[ST_IBF]   = ibf;
        s[ST_CMD]   = cmd;
        s[ST_BURST] = burst;
        s[ST_SCI]   = sci;
        s[ST_SMI]   = smi;
        return s;
    endfunction

endpackage

// File: rtl/ecmb_lane_seq.sv
module ecmb_lane_seq
    import ecmb_pkg::*;
#(
    parameter int LANES = 4,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide,
    input  logic             step,
    input  logic             restart,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(LANES - 1);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_HOME;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            SEQ_HOME: begin
                idx_d = '0;
                if (!restart && step && wide && (LANES > 1)) begin
                    state_d = SEQ_FILL;
                    idx_d   = IDX_W'(1);
                end
            end
            SEQ_FILL: begin
                if (restart || !wide) begin
                    state_d = SEQ_HOME;
                    idx_d   = '0;
                end else if (step) begin
                    if (idx_q == TOP_IDX) begin
                        state_d = SEQ_HOME;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            default: begin
                state_d = SEQ_HOME;
                idx_d   = '0;
            end
        endcase
    end

    always_comb begin
        idx  = idx_q;
        last = step && (!wide || (idx_q == TOP_IDX));
    end

    // R9
    legacy_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide) |=> (idx == '0));

    // R12
    restart_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (idx == '0));

endmodule

// File: rtl/ecmb_flags.sv
module ecmb_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ibf_set,
    input  logic ibf_clr,
    input  logic obf_set,
    input  logic obf_clr,
    input  logic cmd_set,
    input  logic cmd_clr,
    output logic ibf,
    output logic obf,
    output logic cmd,
    output logic irq_ibf,
    output logic irq_obf
);

    logic ibf_q, obf_q, cmd_q;
    logic ibf_d1, obf_d1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ibf_q  <= 1'b0;
            obf_q  <= 1'b0;
            cmd_q  <= 1'b0;
            ibf_d1 <= 1'b0;
            obf_d1 <= 1'b0;
        end else begin
            if (ibf_set)      ibf_q <= 1'b1;
            else if (ibf_clr) ibf_q <= 1'b0;
            if (obf_set)      obf_q <= 1'b1;
            else if (obf_clr) obf_q <= 1'b0;
            if (cmd_set)      cmd_q <= 1'b1;
            else if (cmd_clr) cmd_q <= 1'b0;
            ibf_d1 <= ibf_q;
            obf_d1 <= obf_q;
        end
    end

    always_comb begin
        ibf     = ibf_q;
        obf     = obf_q;
        cmd     = cmd_q;
        irq_ibf = ibf_q && !ibf_d1;
        irq_obf = obf_d1 && !obf_q;
    end

    // R6
    ibf_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ibf |=> !irq_ibf);

    // R6
    obf_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_obf |=> !irq_obf);

    // R6
    ibf_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ibf && ibf_set) |=> irq_ibf);

    // R6
    obf_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (obf && obf_clr && !obf_set) |=> irq_obf);

endmodule

// File: rtl/ecmb_mailbox.sv
module ecmb_mailbox
    import ecmb_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic [ADDR_W-1:0] ctl_addr,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    input  logic [BYTE_W-1:0] ctl_wdata,
    output logic [BYTE_W-1:0] ctl_rdata,
    output logic              irq_ibf,
    output logic              irq_obf
);

    localparam int IDX_W    = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int IN_BASE  = 0;
    localparam int OUT_BASE = LANES;
    localparam int STAT_OFS = 2 * LANES;
    localparam int CTRL_OFS = 2 * LANES + 1;

    logic [LANES-1:0][BYTE_W-1:0] in_q, out_q;
    logic                         wide_q, burst_q, sci_q, smi_q;
    logic                         ibf, obf, cmd;
    logic [IDX_W-1:0]             w_idx, r_idx;
    logic                         w_last, r_last;
    logic [LANES-1:0]             out_hit;
    logic                         host_data_wr, host_cmd_wr, host_data_rd;
    logic                         ctrl_wr, in0_rd;
    logic [BYTE_W-1:0]            status;

    always_comb begin
        host_data_wr = host_wr && !host_sel;
        host_cmd_wr  = host_wr &&  host_sel;
        host_data_rd = host_rd && !host_sel;
        ctrl_wr      = ctl_wr && (ctl_addr == ADDR_W'(CTRL_OFS));
        in0_rd       = ctl_rd && (ctl_addr == ADDR_W'(IN_BASE));
    end

    for (genvar g = 0; g < LANES; g++) begin : g_out_dec
        assign out_hit[g] = ctl_wr && (ctl_addr == ADDR_W'(OUT_BASE + g));
    end

    ecmb_lane_seq #(.LANES(LANES)) u_wseq (
        .clk(clk), .rst_n(rst_n), .wide(wide_q),
        .step(host_data_wr), .restart(host_cmd_wr || ctrl_wr),
        .idx(w_idx), .last(w_last)
    );

    ecmb_lane_seq #(.LANES(LANES)) u_rseq (
        .clk(clk), .rst_n(rst_n), .wide(wide_q),
        .step(host_data_rd), .restart(out_hit[0] || ctrl_wr),
        .idx(r_idx), .last(r_last)
    );

    ecmb_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .ibf_set(host_cmd_wr || (host_data_wr && w_last)),
        .ibf_clr(in0_rd),
        .obf_set(out_hit[0]),
        .obf_clr(host_data_rd && r_last),
        .cmd_set(host_cmd_wr),
        .cmd_clr(host_data_wr),
        .ibf(ibf), .obf(obf), .cmd(cmd),
        .irq_ibf(irq_ibf), .irq_obf(irq_obf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q  <= '0;
            out_q <= '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if ((host_data_wr && (w_idx == IDX_W'(i))) || (host_cmd_wr && (i == 0)))
                    in_q[i] <= host_wdata;
                if (out_hit[i])
                    out_q[i] <= ctl_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q  <= 1'b0;
            burst_q <= 1'b0;
            sci_q   <= 1'b0;
            smi_q   <= 1'b0;
        end else if (ctrl_wr) begin
            wide_q  <= ctl_wdata[CT_WIDE];
            burst_q <= ctl_wdata[CT_BURST];
            sci_q   <= ctl_wdata[CT_SCI];
            smi_q   <= ctl_wdata[CT_SMI];
        end
    end

    always_comb begin
        status     = pack_status(obf, ibf, cmd, burst_q, sci_q, smi_q);
        host_rdata = host_sel ? status : out_q[r_idx];
        ctl_rdata  = '0;
        if (ctl_addr < ADDR_W'(OUT_BASE)) begin
            ctl_rdata = in_q[ctl_addr[IDX_W-1:0]];
        end else if (ctl_addr < ADDR_W'(STAT_OFS)) begin
            ctl_rdata = out_q[ctl_addr[IDX_W-1:0]];
        end else if (ctl_addr == ADDR_W'(STAT_OFS)) begin
            ctl_rdata = status;
        end else if (ctl_addr == ADDR_W'(CTRL_OFS)) begin
            ctl_rdata[CT_WIDE]  = wide_q;
            ctl_rdata[CT_BURST] = burst_q;
            ctl_rdata[CT_SCI]   = sci_q;
            ctl_rdata[CT_SMI]   = smi_q;
        end
    end

    // R2
    data_write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_wr && !wide_q && !ctrl_wr) |=> (ibf && !cmd));

    // R3
    cmd_write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_cmd_wr |=> (cmd && ibf));

    // R4
    ibf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in0_rd && !host_wr) |=> !ibf);

    // R5
    obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit[0] |=> obf);

    // R11
    host_keeps_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr) |=> $stable(out_q));

    // R11
    ctl_keeps_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr) |=> $stable(in_q));

endmodule

// File: tb/ecmb_mailbox_test.sv
module ecmb_mailbox_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [3:0] ctl_addr = '0;
    logic       ctl_wr = 1'b0, ctl_rd = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       irq_ibf, irq_obf;

    always #2 clk = ~clk;

    ecmb_mailbox uut (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ctl_addr(ctl_addr), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .irq_ibf(irq_ibf), .irq_obf(irq_obf)
    );

    // behavioural reference
    int m_in [4];
    int m_out[4];
    bit m_ibf, m_obf, m_cmd, m_wide, m_burst, m_sci, m_smi;
    int m_widx, m_ridx;
    bit m_irq_i, m_irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    function automatic int exp_status();
        return (m_smi << 6) | (m_sci << 5) | (m_burst << 4) | (m_cmd << 3) | (m_ibf << 1) | m_obf;
    endfunction

    function automatic int exp_ctl(int a);
        if (a < 4)  return m_in[a];
        if (a < 8)  return m_out[a - 4];
        if (a == 8) return exp_status();
        if (a == 9) return (m_smi << 6) | (m_sci << 5) | (m_burst << 1) | m_wide;
        return 0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "host_rdata", int'(host_rdata), host_sel ? exp_status() : m_out[m_ridx]);
        chk(tag, "ctl_rdata", int'(ctl_rdata), exp_ctl(int'(ctl_addr)));
        chk(tag, "irq_ibf", int'(irq_ibf), int'(m_irq_i));
        chk(tag, "irq_obf", int'(irq_obf), int'(m_irq_o));
    endtask

    task automatic model_update();
        bit old_i, old_o, si, ci, so, co;
        int a;
        old_i = m_ibf; old_o = m_obf;
        si = 0; ci = 0; so = 0; co = 0;
        a = int'(ctl_addr);
        if (host_wr) begin
            if (host_sel) begin
                m_in[0] = host_wdata; m_cmd = 1; si = 1; m_widx = 0;
            end else begin
                m_in[m_widx] = host_wdata; m_cmd = 0;
                if (!m_wide || m_widx == 3) begin si = 1; m_widx = 0; end
                else m_widx++;
            end
        end
        if (host_rd && !host_sel) begin
            if (!m_wide || m_ridx == 3) begin co = 1; m_ridx = 0; end
            else m_ridx++;
        end
        if (ctl_rd && a == 0) ci = 1;
        if (ctl_wr && a >= 4 && a <= 7) begin
            m_out[a - 4] = ctl_wdata;
            if (a == 4) begin so = 1; m_ridx = 0; end
        end
        if (ctl_wr && a == 9) begin
            m_wide = ctl_wdata[0]; m_burst = ctl_wdata[1];
            m_sci = ctl_wdata[5];  m_smi = ctl_wdata[6];
            m_widx = 0; m_ridx = 0;
        end
        if (si) m_ibf = 1; else if (ci) m_ibf = 0;
        if (so) m_obf = 1; else if (co) m_obf = 0;
        m_irq_i = m_ibf && !old_i;
        m_irq_o = old_o && !m_obf;
    endtask

    // one clock of stimulus, compared against the model
    task automatic cyc(string tag, bit hs, bit hw, bit hr, int hd,
                       int ca, bit cw, bit cr, int cd);
        @(negedge clk);
        host_sel = hs; host_wr = hw; host_rd = hr; host_wdata = 8'(hd);
        ctl_addr = 4'(ca); ctl_wr = cw; ctl_rd = cr; ctl_wdata = 8'(cd);
        #1;
        compare(tag);
        model_update();
    endtask

    task automatic idle(string tag, bit hs, int ca);
        cyc(tag, hs, 0, 0, 0, ca, 0, 0, 0);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_out[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, several views
        idle("R1", 1, 8);
        idle("R1", 0, 9);
        idle("R1", 0, 0);

        // R7 host status read is side-effect free
        cyc("R7", 1, 0, 1, 0, 8, 0, 0, 0);
        idle("R7", 1, 8);

        // R2 legacy data write, R6 IBF pulse
        cyc("R2", 0, 1, 0, 'h5A, 0, 0, 0, 0);
        idle("R6", 1, 0);
        idle("R2", 1, 8);
        // R4 controller drains slot 0
        cyc("R4", 1, 0, 0, 0, 0, 0, 1, 0);
        idle("R4", 1, 8);

        // R3 command write
        cyc("R3", 1, 1, 0, 'h81, 8, 0, 0, 0);
        idle("R3", 1, 0);
        // R4 same-cycle set and clear: IBF stays, no fresh pulse
        cyc("R4", 0, 1, 0, 'h22, 0, 0, 1, 0);
        idle("R4", 1, 0);
        cyc("R4", 1, 0, 0, 0, 0, 0, 1, 0);
        idle("R4", 1, 8);
        // IBF goes 0 -> 1 in the same cycle as a clear request: pulse expected
        cyc("R6", 1, 1, 0, 'h44, 0, 0, 1, 0);
        idle("R6", 1, 8);

        // R5 controller posts, host drains; R6 OBF pulse
        cyc("R5", 1, 0, 0, 0, 4, 1, 0, 'h3C);
        idle("R5", 0, 4);
        cyc("R5", 0, 0, 1, 0, 8, 0, 0, 0);
        idle("R6", 1, 8);
        // R5 same-cycle set and clear: set wins
        cyc("R5", 1, 0, 0, 0, 4, 1, 0, 'h11);
        cyc("R5", 0, 0, 1, 0, 4, 1, 0, 'h12);
        idle("R5", 1, 8);
        cyc("R5", 0, 0, 1, 0, 8, 0, 0, 0);

        // R8 control bits and read back
        cyc("R8", 1, 0, 0, 0, 9, 1, 0, 'hFE);
        idle("R8", 1, 9);
        idle("R8", 1, 8);
        cyc("R8", 1, 0, 0, 0, 9, 1, 0, 'h00);
        idle("R8", 1, 9);

        // R11 controller writes to input slots are ignored
        cyc("R11", 1, 0, 0, 0, 1, 1, 0, 'h99);
        idle("R11", 1, 1);

        // R9 four-byte host writes
        cyc("R9", 1, 0, 0, 0, 9, 1, 0, 'h01);
        for (int b = 0; b < 4; b++) begin
            cyc("R9", 0, 1, 0, 'hA0 + b, 8, 0, 0, 0);
            idle("R9", 1, b);
        end
        cyc("R9", 1, 0, 0, 0, 0, 0, 1, 0);
        cyc("R9", 0, 1, 0, 'hB0, 8, 0, 0, 0);
        cyc("R3", 1, 1, 0, 'hC1, 8, 0, 0, 0);
        cyc("R9", 0, 1, 0, 'hB1, 0, 0, 0, 0);
        idle("R9", 1, 1);

        // R10 four-byte host reads, with R11 full duplex traffic
        cyc("R10", 1, 0, 0, 0, 5, 1, 0, 'h15);
        cyc("R10", 1, 0, 0, 0, 6, 1, 0, 'h16);
        cyc("R10", 1, 0, 0, 0, 7, 1, 0, 'h17);
        idle("R11", 1, 8);
        cyc("R10", 1, 0, 0, 0, 4, 1, 0, 'h14);
        for (int b = 0; b < 4; b++) begin
            cyc("R10", 0, 0, 1, 0, 8, 0, 0, 0);
            cyc("R11", 0, 1, 0, 'h60 + b, 4 + b, 0, 0, 0);
        end
        idle("R10", 1, 8);

        // R12 control write restarts partial transfers
        cyc("R12", 0, 1, 0, 'h70, 8, 0, 0, 0);
        cyc("R12", 1, 0, 0, 0, 4, 1, 0, 'h24);
        cyc("R12", 0, 0, 1, 0, 8, 0, 0, 0);
        cyc("R12", 1, 0, 0, 0, 9, 1, 0, 'h01);
        cyc("R12", 0, 1, 0, 'h71, 0, 0, 0, 0);
        idle("R12", 0, 0);

        // R11 pseudo-random mixed traffic from both sides
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            bit hs, hw, hr, cw, cr;
            int ca;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            hs = lfsr[0];
            hw = lfsr[1] & lfsr[2];
            hr = !hw && lfsr[3];
            ca = int'(lfsr[7:4]) % 11;
            cw = lfsr[8] & lfsr[9] & (ca != 9 || lfsr[10]);
            cr = lfsr[11];
            cyc("R11", hs, hw, hr, int'(lfsr[15:8]), ca, cw, cr, int'(lfsr[14:7]));
        end
        idle("R11", 1, 8);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule